// File: doc/BRIEF.md
# Precise Exception Commit Arbiter

This block decides, for a five-stage in-order pipeline, when control must leave the running program for the exception handler. Four detectors sit in the pipeline. The fetch detector reports a bad instruction address. The decode detector reports an opcode it cannot recognise. The execute detector reports an arithmetic overflow. The memory detector reports a bad data address. A detector does not redirect anything when it fires. Instead, the block records the fault in a small tag that travels with the instruction, one register per stage boundary. Only when the instruction sits at the memory-stage commit point does the block decide what to do. This keeps every exception precise: everything older has completed and nothing younger has touched architectural state.

At the commit point the block looks at three things: the recorded tag, the data-address detector, and an external interrupt request qualified by an enable. If it acts, it raises kill strobes for fetch, decode and execute. It suppresses the writeback of the committing instruction. It steers fetch to a single fixed handler address. It also strobes writes of a cause code and of the exception PC. The datapath, the handler code and device-level interrupt prioritisation are outside this block.

Top module: `exc_commit_arbiter`

## Requirements
- R1: A fault flagged in fetch, decode or execute produces no redirect, kill or strobe until that instruction reaches the commit point. The block acts in the cycle the instruction is at the commit point, three cycles after its fetch cycle when nothing is flushed.
- R2: When one instruction collects several faults, the cause reported is the one from the earliest stage. The codes are 1 for instruction-address fault, 2 for illegal opcode, 3 for overflow and 4 for data-address fault, and `cause_o` is 3 bits wide.
- R3: An interrupt taken at the commit point reports cause 0, whatever faults the committing instruction carries.
- R4: An interrupt is taken only when `irq_req_i` and `irq_en_i` are both high and the commit stage holds a valid instruction.
- R5: When the block acts, `cause_we_o` and `epc_we_o` pulse for that cycle. `epc_o` carries the PC of the instruction at the commit point, which does not complete.
- R6: When the block acts, `kill_f_o`, `kill_d_o`, `kill_e_o` and `kill_wb_o` are high and `redirect_o` is high with `redirect_pc_o` equal to `HANDLER_PC` (default 32'h0000_1010).
- R7: Instructions younger than the committing one are flushed when the block acts. A fault flagged on them in later cycles never reaches the commit point.
- R8: A bubble never raises an exception. Fault flags in a stage holding no valid instruction are ignored.
- R9: With no fault and no qualified interrupt at the commit point, every kill, redirect and write strobe stays low, including during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| f_valid_i | input | 1 | Fetch stage holds a valid instruction |
| f_pc_i | input | PC_W | PC of the instruction in fetch |
| f_iaddr_fault_i | input | 1 | Instruction-address fault on the fetch instruction |
| d_illegal_i | input | 1 | Illegal opcode on the decode instruction |
| e_overflow_i | input | 1 | Overflow on the execute instruction |
| m_daddr_fault_i | input | 1 | Data-address fault on the memory instruction |
| irq_req_i | input | 1 | External interrupt request |
| irq_en_i | input | 1 | Interrupt enable |
| kill_f_o | output | 1 | Kill fetch |
| kill_d_o | output | 1 | Kill decode |
| kill_e_o | output | 1 | Kill execute |
| kill_wb_o | output | 1 | Suppress writeback of the committing instruction |
| redirect_o | output | 1 | Force fetch to the handler |
| redirect_pc_o | output | PC_W | Handler address |
| cause_we_o | output | 1 | Cause register write strobe |
| cause_o | output | 3 | Cause code |
| epc_we_o | output | 1 | Exception PC write strobe |
| epc_o | output | PC_W | Exception PC value |

## Verification
The hardest case to reach is a fault raised on a younger instruction while an older one is committing. The younger fault must be discarded, so the check depends on lining up per-stage flags cycle by cycle against instructions that are in flight. The stimulus drives one flag per stage each cycle. A faulting instruction is followed by more fetches whose decode and execute flags fire in the cycles after the flush. A reference pipeline in the bench, built from the requirements, predicts that these flags land on bubbles and produce no action. Stacked faults on a single instruction, with and without a simultaneous interrupt, cover the priority order.

// File: rtl/excarb_pkg.sv
package excarb_pkg;

    typedef enum logic [2:0] {
        CAUSE_IRQ     = 3'd0,
        CAUSE_IADDR   = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DADDR   = 3'd4
    } cause_e;

    // exception tag carried by one in-flight instruction
    typedef struct packed {
        logic   valid;
        logic   pend;
        cause_e code;
    } slot_t;

    // record a newly detected fault unless an earlier stage already did
    function automatic slot_t tag_fault(slot_t s, logic flag, cause_e c);
        slot_t r;
        r = s;
        if (s.valid && !s.pend && flag) begin
            r.pend = 1'b1;
            r.code = c;
        end
        return r;
    endfunction

endpackage

// File: rtl/exc_pipe_slot.sv
module exc_pipe_slot
    import excarb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            flush_i,
    input  slot_t           in_info_i,
    input  logic [PC_W-1:0] in_pc_i,
    output slot_t           q_info_o,
    output logic [PC_W-1:0] q_pc_o
);

    typedef struct packed {
        slot_t           info;
        logic [PC_W-1:0] pc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.info = in_info_i;
        st_d.pc   = in_pc_i;
        if (flush_i) begin
            st_d.info.valid = 1'b0;
            st_d.info.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q_info_o = st_q.info;
    assign q_pc_o   = st_q.pc;

    // an already recorded earlier fault is never replaced on the way down
    assert_earliest_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_info_i.valid && in_info_i.pend && !flush_i)
        |=> (q_info_o.pend && q_info_o.code == $past(in_info_i.code)));

    // flushed younger instructions leave the slot empty
    assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (!q_info_o.valid && !q_info_o.pend));

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
    import excarb_pkg::*;
(
    input  slot_t  m_info_i,
    input  logic   irq_req_i,
    input  logic   irq_en_i,
    output logic   take_o,
    output logic   irq_take_o,
    output cause_e cause_o
);

    always_comb begin
        irq_take_o = m_info_i.valid && irq_req_i && irq_en_i;
        take_o     = m_info_i.valid && (irq_take_o || m_info_i.pend);
        cause_o    = irq_take_o ? CAUSE_IRQ : m_info_i.code;
    end

endmodule

// File: rtl/exc_commit_arbiter.sv
module exc_commit_arbiter
    import excarb_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_1010
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            f_valid_i,
    input  logic [PC_W-1:0] f_pc_i,
    input  logic            f_iaddr_fault_i,
    input  logic            d_illegal_i,
    input  logic            e_overflow_i,
    input  logic            m_daddr_fault_i,
    input  logic            irq_req_i,
    input  logic            irq_en_i,
    output logic            kill_f_o,
    output logic            kill_d_o,
    output logic            kill_e_o,
    output logic            kill_wb_o,
    output logic            redirect_o,
    output logic [PC_W-1:0] redirect_pc_o,
    output logic            cause_we_o,
    output logic [2:0]      cause_o,
    output logic            epc_we_o,
    output logic [PC_W-1:0] epc_o
);

    // tag registers at the F/D, D/E and E/M boundaries
    localparam int NSLOT = 3;

    slot_t           st_in [NSLOT];
    slot_t           st_q  [NSLOT];
    logic [PC_W-1:0] pc_in [NSLOT];
    logic [PC_W-1:0] pc_q  [NSLOT];
    logic [NSLOT-1:0] stage_flag;
    slot_t           head_entry;
    slot_t           commit_info;
    logic            take, irq_take;
    cause_e          take_cause;

    assign stage_flag = {e_overflow_i, d_illegal_i, f_iaddr_fault_i};

    always_comb begin
        head_entry       = '0;
        head_entry.valid = f_valid_i;
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        if (i == 0) begin : g_head
            assign st_in[i] = tag_fault(head_entry, stage_flag[i], cause_e'(i + 1));
            assign pc_in[i] = f_pc_i;
        end else begin : g_body
            assign st_in[i] = tag_fault(st_q[i-1], stage_flag[i], cause_e'(i + 1));
            assign pc_in[i] = pc_q[i-1];
        end
        exc_pipe_slot #(.PC_W(PC_W)) u_slot (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .flush_i   (take),
            .in_info_i (st_in[i]),
            .in_pc_i   (pc_in[i]),
            .q_info_o  (st_q[i]),
            .q_pc_o    (pc_q[i])
        );
    end

    assign commit_info = tag_fault(st_q[NSLOT-1], m_daddr_fault_i, CAUSE_DADDR);

    exc_commit_unit u_commit (
        .m_info_i   (commit_info),
        .irq_req_i  (irq_req_i),
        .irq_en_i   (irq_en_i),
        .take_o     (take),
        .irq_take_o (irq_take),
        .cause_o    (take_cause)
    );

    assign kill_f_o      = take;
    assign kill_d_o      = take;
    assign kill_e_o      = take;
    assign kill_wb_o     = take;
    assign redirect_o    = take;
    assign redirect_pc_o = HANDLER_PC;
    assign cause_we_o    = take;
    assign cause_o       = take_cause;
    assign epc_we_o      = take;
    assign epc_o         = pc_q[NSLOT-1];

    // a bubble at commit never triggers the handler
    assert_bubble_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q[NSLOT-1].valid |-> !cause_we_o);

    // qualified interrupt beats any synchronous fault
    assert_irq_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_req_i && irq_en_i && st_q[NSLOT-1].valid) |-> (cause_we_o && cause_o == 3'd0));

    // no interrupt is taken while disabled
    assert_irq_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_en_i && !st_q[NSLOT-1].pend && !m_daddr_fault_i) |-> !redirect_o);

    // a clean instruction at commit passes untouched
    assert_defer_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q[NSLOT-1].valid && !st_q[NSLOT-1].pend && !m_daddr_fault_i && !irq_req_i)
        |-> !kill_wb_o);

    // acting empties the whole in-flight window by the next cycle
    assert_window_flushed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> (!st_q[0].valid && !st_q[1].valid && !st_q[2].valid));

    // synchronous fault causes never report the interrupt code
    assert_sync_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_we_o && !irq_take) |-> (cause_o >= 3'd1 && cause_o <= 3'd4));

endmodule

// File: tb/tb_exc_commit_arbiter.sv
module tb_exc_commit_arbiter;

    localparam int          PERIOD  = 10;
    localparam logic [31:0] HANDLER = 32'h0000_1010;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        f_valid = 0, f_fault = 0, d_ill = 0, e_ovf = 0, m_da = 0, irq = 0, irq_en = 0;
    logic [31:0] f_pc = '0;
    logic        kill_f, kill_d, kill_e, kill_wb, redirect, cause_we, epc_we;
    logic [31:0] redirect_pc, epc;
    logic [2:0]  cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    exc_commit_arbiter dut (
        .clk_i(clk), .rst_ni(rst_n),
        .f_valid_i(f_valid), .f_pc_i(f_pc), .f_iaddr_fault_i(f_fault),
        .d_illegal_i(d_ill), .e_overflow_i(e_ovf), .m_daddr_fault_i(m_da),
        .irq_req_i(irq), .irq_en_i(irq_en),
        .kill_f_o(kill_f), .kill_d_o(kill_d), .kill_e_o(kill_e), .kill_wb_o(kill_wb),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc),
        .cause_we_o(cause_we), .cause_o(cause), .epc_we_o(epc_we), .epc_o(epc)
    );

    typedef struct {
        string       tag;
        bit          take;
        int          cause;
        logic [31:0] epc;
    } exp_t;

    exp_t exp_q[$];

    // reference pipeline: index 0 = decode, 1 = execute, 2 = memory/commit
    bit          mv [3];
    bit          mp [3];
    int          mc [3];
    logic [31:0] mpc [3];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit fv, logic [31:0] pc, bit ff, bit di, bit eo,
                        bit md, bit rq, bit en);
        exp_t e;
        bit   pend, irqt;
        int   code;
        @(negedge clk);
        f_valid = fv; f_pc = pc; f_fault = ff; d_ill = di; e_ovf = eo;
        m_da = md; irq = rq; irq_en = en;
        pend   = mv[2] && (mp[2] || md);
        code   = mp[2] ? mc[2] : 4;
        irqt   = mv[2] && rq && en;
        e.tag  = tag;
        e.take = irqt || pend;
        e.cause = irqt ? 0 : code;
        e.epc  = mpc[2];
        exp_q.push_back(e);
        if (e.take) begin
            for (int k = 0; k < 3; k++) begin mv[k] = 0; mp[k] = 0; end
        end else begin
            mv[2] = mv[1]; mpc[2] = mpc[1];
            mp[2] = mv[1] && (mp[1] || eo); mc[2] = mp[1] ? mc[1] : 3;
            mv[1] = mv[0]; mpc[1] = mpc[0];
            mp[1] = mv[0] && (mp[0] || di); mc[1] = mp[0] ? mc[0] : 2;
            mv[0] = fv; mpc[0] = pc;
            mp[0] = fv && ff; mc[0] = 1;
        end
    endtask

    // one instruction, one flag per stage as it passes, interrupt at commit
    task automatic single(string tag, logic [31:0] pc, bit ff, bit di, bit eo, bit md,
                          bit rq, bit en);
        step(tag, 1, pc, ff, 0, 0, 0, 0, 0);
        step(tag, 0, 0, 0, di, 0, 0, 0, 0);
        step(tag, 0, 0, 0, 0, eo, 0, 0, 0);
        step(tag, 0, 0, 0, 0, 0, md, rq, en);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // monitor: pop expected item and compare after outputs settle
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.tag, {31'd0, cause_we}, {31'd0, e.take});
            chk("R6", {28'd0, kill_f, kill_d, kill_e, kill_wb}, e.take ? 32'hF : 32'h0);
            chk("R6", {31'd0, redirect}, {31'd0, e.take});
            chk("R5", {31'd0, epc_we}, {31'd0, e.take});
            if (e.take) begin
                chk(e.tag, {29'd0, cause}, e.cause);
                chk("R5", epc, e.epc);
                chk("R6", redirect_pc, HANDLER);
            end
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin mv[k] = 0; mp[k] = 0; mc[k] = 0; mpc[k] = '0; end
        // R9 / R8: during reset nothing fires, even with flags and interrupt up
        irq = 1; irq_en = 1; m_da = 1; d_ill = 1;
        repeat (3) @(negedge clk);
        #2;
        chk("R9", {30'd0, cause_we, redirect}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        irq = 0; irq_en = 0; m_da = 0; d_ill = 0;

        // R9: clean stream
        for (int k = 0; k < 6; k++) step("R9", 1, 32'h100 + 4*k, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step("R9", 0, 0, 0, 0, 0, 0, 0, 0);

        // R1 + R7: fetch fault acted on at commit; younger faults discarded
        step("R1", 1, 32'h200, 1, 0, 0, 0, 0, 0);
        step("R1", 1, 32'h204, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 32'h208, 0, 0, 0, 0, 0, 0);
        step("R1", 1, 32'h20C, 0, 1, 1, 0, 0, 0);
        step("R7", 1, 32'h210, 0, 1, 1, 1, 0, 0);
        step("R7", 1, 32'h214, 0, 1, 1, 1, 0, 0);
        step("R7", 1, 32'h218, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) step("R7", 0, 0, 0, 0, 0, 0, 0, 0);

        // R2: stacked faults, earliest stage wins
        single("R2", 32'h300, 1, 1, 1, 1, 0, 0);
        single("R2", 32'h304, 0, 1, 1, 1, 0, 0);
        single("R2", 32'h308, 0, 0, 1, 1, 0, 0);
        single("R2", 32'h30C, 0, 0, 0, 1, 0, 0);

        // R3: interrupt overrides faults
        single("R3", 32'h400, 0, 0, 0, 0, 1, 1);
        single("R3", 32'h404, 1, 1, 0, 1, 1, 1);

        // R4: disabled interrupt ignored, fault still handled
        single("R4", 32'h500, 0, 0, 0, 0, 1, 0);
        single("R4", 32'h504, 0, 0, 0, 1, 1, 0);
        // R4: enabled interrupt with empty commit slot
        for (int k = 0; k < 2; k++) step("R4", 0, 0, 0, 0, 0, 0, 1, 1);

        // R8: flags on bubbles only
        for (int k = 0; k < 4; k++) step("R8", 0, 32'h600, 1, 1, 1, 1, 0, 0);
        for (int k = 0; k < 3; k++) step("R8", 0, 0, 0, 0, 0, 0, 0, 0);

        // R3 / R5: interrupt in a streaming sequence
        for (int k = 0; k < 4; k++) step("R5", 1, 32'h700 + 4*k, 0, 0, 0, 0, 0, 0);
        step("R3", 1, 32'h710, 0, 0, 0, 0, 1, 1);
        for (int k = 0; k < 5; k++) step("R9", 1, 32'h1010 + 4*k, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step("R9", 0, 0, 0, 0, 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule